// File: doc/BRIEF.md
# MAC Transmit Pause and Backpressure Controller

This block decides when a MAC transmitter may begin a new frame. It keeps a pause timer counted in quanta. The timer is loaded from a pause time taken from a received control frame. While the timer is non-zero, the block holds off new frame starts. Each quantum normally spans 64 byte-times, which are counted on a byte-time tick. A test control shortens a quantum to a single byte-time. A second test control forces the paused condition exactly as a non-zero received pause would.

A third test control puts the link into backpressure. The block then requests a preamble jam, which raises carrier sense at the far end. Backpressure does not stop the system's own frames. While a frame is being sent, the jam request drops, and it returns once the frame is done.

Frame starts use a valid/ready handshake. The transmitter raises `tx_valid_i` and holds it until it sees `tx_ready_o`. A frame starts on any cycle where both are high. `tx_ready_o` is low while a frame is in progress, and it stays low until `tx_done_i` closes the frame. It is also low while paused. A pause never cuts off a frame that has already started; it only blocks the next start.

Top module: `txpause_ctrl`

## Requirements
- R1: After reset, `paused_o` is 0, `jam_o` is 0 and `tx_ready_o` is 1. The quanta count is 0 and no frame is in progress.
- R2: When `pause_load_i` is high with a non-zero `pause_quanta_i`, `paused_o` is 1 and `tx_ready_o` is 0 from the next cycle on.
- R3: With `tst_short_i` at 0, a loaded count of N ends after exactly 64·N byte ticks. `paused_o` falls in the cycle after the 64·N-th tick.
- R4: With `tst_short_i` at 1, each byte tick ends one quantum, so a count of N ends after N ticks.
- R5: A load of value 0 ends any running pause from the next cycle on. After it, `paused_o` equals `tst_pause_i`.
- R6: A non-zero load while a pause is running restarts the timer from the new value. The partial quantum is discarded.
- R7: While `tst_pause_i` is 1, `paused_o` is 1 and `tx_ready_o` is 0. `paused_o` is 0 only when the count is zero and `tst_pause_i` is 0.
- R8: A frame starts on a cycle where `tx_valid_i` and `tx_ready_o` are both high. From the next cycle, `tx_ready_o` stays 0 until the cycle after `tx_done_i`. A pause loaded during the frame does not end it, but it blocks the next start.
- R9: `jam_o` is 1 exactly when `tst_bp_i` is 1 and no frame is in progress. Backpressure alone never lowers `tx_ready_o`.
- R10: The pause count changes only on a cycle with `byte_tick_i` high or `pause_load_i` high. With no ticks, `paused_o` stays 1 indefinitely.
- R11: When a load and a byte tick fall in the same cycle, the load wins. That tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick_i | input | 1 | One-cycle pulse per byte-time |
| pause_load_i | input | 1 | Strobe that loads `pause_quanta_i` into the timer |
| pause_quanta_i | input | 16 | Pause time in quanta |
| tst_short_i | input | 1 | Test: a quantum lasts one byte-time |
| tst_pause_i | input | 1 | Test: force the paused condition |
| tst_bp_i | input | 1 | Test: force backpressure preamble |
| tx_valid_i | input | 1 | Transmitter has a frame ready to start |
| tx_ready_o | output | 1 | Frame start permitted this cycle |
| tx_done_i | input | 1 | Pulse at the end of the current frame |
| jam_o | output | 1 | Preamble jam request |
| paused_o | output | 1 | Transmission held off by pause |

## Verification
The hardest case to reach is a pause load that arrives while a frame is in flight, with the pause outlasting the end of that frame. The bench starts a frame, loads a pause in the shortcut mode a few cycles later, and keeps `tx_valid_i` high throughout. It then releases `tx_done_i` while quanta remain, so the next start must wait for the timer rather than for the frame. Same-cycle load-and-tick collisions and mid-quantum reloads are forced on purpose. A reference model tracks the byte position inside the quantum, so an error of one tick in either direction shows up.

// File: rtl/txp_pkg.sv
package txp_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_BUSY = 1'b1
  } gate_state_e;

  localparam int unsigned TXP_QUANTUM_DEF = 64;
  localparam int unsigned TXP_QW_DEF      = 16;
endpackage

// File: rtl/txp_quantum_div.sv
module txp_quantum_div #(
  parameter int unsigned QUANTUM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic shortcut_i,
  output logic quantum_end_o
);
  localparam int unsigned BW = (QUANTUM > 2) ? $clog2(QUANTUM) : 1;
  localparam logic [BW-1:0] LAST = BW'(QUANTUM - 1);

  logic [BW-1:0] byte_q;
  logic          at_last;

  assign at_last       = (byte_q == LAST);
  assign quantum_end_o = tick_i & run_i & ~restart_i & (shortcut_i | at_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (restart_i) begin
      byte_q <= '0;
    end else if (tick_i && run_i) begin
      if (shortcut_i || at_last) byte_q <= '0;
      else                       byte_q <= byte_q + 1'b1;
    end
  end
endmodule

// File: rtl/txp_pause_timer.sv
module txp_pause_timer #(
  parameter int unsigned QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [QW-1:0] load_val_i,
  input  logic          quantum_end_i,
  output logic          run_o
);
  logic [QW-1:0] quanta_q;

  assign run_o = (quanta_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quanta_q <= '0;
    end else if (load_i) begin
      quanta_q <= load_val_i;
    end else if (quantum_end_i && run_o) begin
      quanta_q <= quanta_q - 1'b1;
    end
  end
endmodule

// File: rtl/txp_frame_gate.sv
module txp_frame_gate
  import txp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic valid_i,
  input  logic done_i,
  input  logic bp_i,
  output logic ready_o,
  output logic jam_o
);
  gate_state_e state_q;
  logic        start;

  assign ready_o = (state_q == GATE_IDLE) & ~hold_i;
  assign start   = valid_i & ready_o;
  assign jam_o   = bp_i & (state_q == GATE_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
    end else begin
      unique case (state_q)
        GATE_IDLE: if (start)  state_q <= GATE_BUSY;
        GATE_BUSY: if (done_i) state_q <= GATE_IDLE;
        default:               state_q <= GATE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txpause_ctrl.sv
module txpause_ctrl
  import txp_pkg::*;
#(
  parameter int unsigned QUANTUM = TXP_QUANTUM_DEF,
  parameter int unsigned QW      = TXP_QW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_tick_i,
  input  logic          pause_load_i,
  input  logic [QW-1:0] pause_quanta_i,
  input  logic          tst_short_i,
  input  logic          tst_pause_i,
  input  logic          tst_bp_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  input  logic          tx_done_i,
  output logic          jam_o,
  output logic          paused_o
);
  logic timer_run;
  logic q_end;

  txp_quantum_div #(.QUANTUM(QUANTUM)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (byte_tick_i),
    .run_i        (timer_run),
    .restart_i    (pause_load_i),
    .shortcut_i   (tst_short_i),
    .quantum_end_o(q_end)
  );

  txp_pause_timer #(.QW(QW)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (pause_load_i),
    .load_val_i   (pause_quanta_i),
    .quantum_end_i(q_end),
    .run_o        (timer_run)
  );

  assign paused_o = timer_run | tst_pause_i;

  txp_frame_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (paused_o),
    .valid_i(tx_valid_i),
    .done_i (tx_done_i),
    .bp_i   (tst_bp_i),
    .ready_o(tx_ready_o),
    .jam_o  (jam_o)
  );
endmodule

// File: rtl/txp_ctrl_chk.sv
module txp_ctrl_chk #(
  parameter int unsigned QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_tick_i,
  input logic          pause_load_i,
  input logic [QW-1:0] pause_quanta_i,
  input logic          tst_pause_i,
  input logic          tst_bp_i,
  input logic          tx_valid_i,
  input logic          tx_ready_o,
  input logic          jam_o,
  input logic          paused_o
);
  // R2
  load_nonzero_pauses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_load_i && pause_quanta_i != '0) |=> (paused_o && !tx_ready_o));

  // R5
  load_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_load_i && pause_quanta_i == '0) |=> (paused_o == tst_pause_i));

  // R7
  test_pause_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_pause_i |-> (paused_o && !tx_ready_o));

  // R8
  start_closes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R9
  jam_needs_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |-> tst_bp_i);

  // R9
  bp_not_blocking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_o && !paused_o) |-> tx_ready_o);

  // R10
  idle_timer_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_tick_i && !pause_load_i && paused_o && !tst_pause_i) |=>
      (paused_o || tst_pause_i || !$past(paused_o)) || $past(tst_pause_i));
endmodule

bind txpause_ctrl txp_ctrl_chk #(.QW(QW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_tick_i   (byte_tick_i),
  .pause_load_i  (pause_load_i),
  .pause_quanta_i(pause_quanta_i),
  .tst_pause_i   (tst_pause_i),
  .tst_bp_i      (tst_bp_i),
  .tx_valid_i    (tx_valid_i),
  .tx_ready_o    (tx_ready_o),
  .jam_o         (jam_o),
  .paused_o      (paused_o)
);

// File: tb/txpause_ctrl_tb.sv
module txpause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_tick_i = 1'b0;
  logic        pause_load_i = 1'b0;
  logic [15:0] pause_quanta_i = '0;
  logic        tst_short_i = 1'b0;
  logic        tst_pause_i = 1'b0;
  logic        tst_bp_i = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic        tx_done_i = 1'b0;
  logic        tx_ready_o;
  logic        jam_o;
  logic        paused_o;

  always #2 clk = ~clk;

  txpause_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .byte_tick_i(byte_tick_i),
    .pause_load_i(pause_load_i), .pause_quanta_i(pause_quanta_i),
    .tst_short_i(tst_short_i), .tst_pause_i(tst_pause_i), .tst_bp_i(tst_bp_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_done_i(tx_done_i),
    .jam_o(jam_o), .paused_o(paused_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_req = "R1";

  int m_quanta = 0;
  int m_byte   = 0;
  bit m_frame  = 0;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit e_paused();
    return (m_quanta != 0) || tst_pause_i;
  endfunction

  task automatic cyc();
    bit ex_ready;
    bit start;
    #1;
    ex_ready = !e_paused() && !m_frame;
    chk({cur_req, " paused"}, paused_o, e_paused());
    chk({cur_req, " ready"},  tx_ready_o, ex_ready);
    chk({cur_req, " jam"},    jam_o, tst_bp_i && !m_frame);
    start = tx_valid_i && ex_ready;
    @(posedge clk);
    if (start) m_frame = 1;
    else if (tx_done_i) m_frame = 0;
    if (pause_load_i) begin
      m_quanta = pause_quanta_i;
      m_byte   = 0;
    end else if (byte_tick_i && m_quanta != 0) begin
      if (tst_short_i || m_byte == 63) begin
        m_quanta--;
        m_byte = 0;
      end else m_byte++;
    end
    @(negedge clk);
  endtask

  task automatic load(int v);
    pause_load_i = 1; pause_quanta_i = 16'(v);
    cyc();
    pause_load_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      byte_tick_i = 1; cyc();
    end
    byte_tick_i = 0;
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk("R1 paused", paused_o, 1'b0);
    chk("R1 jam", jam_o, 1'b0);
    chk("R1 ready", tx_ready_o, 1'b1);
    cyc();

    cur_req = "R2";
    load(2);
    chk("R2 paused after load", paused_o, 1'b1);
    chk("R2 ready low", tx_ready_o, 1'b0);

    cur_req = "R3";
    ticks(127);
    chk("R3 still paused at 127", paused_o, 1'b1);
    ticks(1);
    chk("R3 released at 128", paused_o, 1'b0);

    cur_req = "R10";
    load(1);
    for (int i = 0; i < 100; i++) cyc();
    chk("R10 no tick holds pause", paused_o, 1'b1);
    for (int i = 0; i < 64; i++) begin
      byte_tick_i = 1; cyc();
      byte_tick_i = 0; cyc(); cyc();
    end
    chk("R10 sparse ticks end pause", paused_o, 1'b0);

    cur_req = "R4";
    tst_short_i = 1;
    load(5);
    ticks(4);
    chk("R4 paused after 4", paused_o, 1'b1);
    ticks(1);
    chk("R4 released after 5", paused_o, 1'b0);
    tst_short_i = 0;

    cur_req = "R5";
    load(3);
    ticks(70);
    load(0);
    chk("R5 zero load clears", paused_o, 1'b0);

    cur_req = "R6";
    load(1);
    ticks(40);
    load(1);
    ticks(63);
    chk("R6 reload restarts quantum", paused_o, 1'b1);
    ticks(1);
    chk("R6 reload ends after 64", paused_o, 1'b0);

    cur_req = "R11";
    load(1);
    ticks(63);
    byte_tick_i = 1;
    load(1);
    ticks(63);
    chk("R11 collided tick ignored", paused_o, 1'b1);
    ticks(1);

    cur_req = "R7";
    tst_pause_i = 1;
    cyc();
    chk("R7 forced pause", paused_o, 1'b1);
    tst_short_i = 1;
    load(2);
    tst_pause_i = 0;
    cyc();
    chk("R7 count keeps pause", paused_o, 1'b1);
    ticks(2);
    chk("R7 both clear", paused_o, 1'b0);
    tst_short_i = 0;

    cur_req = "R8";
    tx_valid_i = 1;
    cyc();
    chk("R8 busy after start", tx_ready_o, 1'b0);
    cyc();
    tst_short_i = 1;
    load(3);
    cyc(); cyc();
    tx_done_i = 1; cyc(); tx_done_i = 0;
    chk("R8 pause blocks next start", tx_ready_o, 1'b0);
    ticks(3);
    chk("R8 start after pause", tx_ready_o, 1'b1);
    cyc();
    tx_valid_i = 0;
    tx_done_i = 1; cyc(); tx_done_i = 0;
    tst_short_i = 0;

    cur_req = "R9";
    tst_bp_i = 1;
    cyc();
    chk("R9 jam idle", jam_o, 1'b1);
    chk("R9 ready under bp", tx_ready_o, 1'b1);
    tx_valid_i = 1; cyc(); tx_valid_i = 0;
    chk("R9 jam drops in frame", jam_o, 1'b0);
    cyc();
    tx_done_i = 1; cyc(); tx_done_i = 0;
    chk("R9 jam returns", jam_o, 1'b1);
    tst_bp_i = 0;
    cyc();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule